// File: doc/BRIEF.md
# Prescaled Overflow Timer

This block is a free-running up-counter, 8 or 16 bits wide, for a microcontroller-style peripheral set. A 3-bit clock-select code sets how often the counter advances. The options are stopped, one of five divisions of the system clock, or the falling or rising edges of an external pin. The external pin is synchronized on chip before any edge is detected.

When the count wraps from all ones to zero, an overflow flag is set. An interrupt request is raised while the flag, a mask bit and a global enable input are all high. The flag clears when the interrupt is acknowledged, or when software writes a one to it.

Software reaches the block through a small register bus. The bus has a write strobe, a 2-bit address, and write and read data as wide as the counter. Reads are combinational from the address.

Top module: `ovf_timer`

## Requirements
- R1: After reset the count, the clock-select code, the overflow flag and the mask bit are all 0, and the interrupt request is low.
- R2: With clock-select code 0, the count holds its value.
- R3: Clock-select codes 1, 2, 3, 4 and 5 advance the count once every 1, 8, 64, 256 and 1024 system clocks respectively. The prescaler restarts from zero when a different code is written, so the first advance comes that many clocks after the write. Rewriting the current code does not restart it.
- R4: Code 6 advances the count on falling edges of `ext_clk`, and code 7 on rising edges. An edge first sampled at clock edge k changes the count at clock edge k+2.
- R5: The count wraps modulo 2^W. When an advance takes it from all ones to zero, flag bit 0 is set.
- R6: `irq` is high exactly while flag bit 0, mask bit 0 and `gie` are all 1.
- R7: A one-cycle `irq_ack` pulse clears the flag, so `irq` is low in the following cycle.
- R8: Writing address 2 with data bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R9: A write to the count register in the same cycle as an advance takes priority, and the advance is dropped.
- R10: Register map: address 0 is the count (all W bits), address 1 is the clock-select code in bits [2:0], address 2 is the flag in bit 0, and address 3 is the mask in bit 0. Unused read bits are 0.
- R11: An overflow in the same cycle as a flag clear (by acknowledge or by write) leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr` |
| ext_clk | input | 1 | External count source, asynchronous |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check several behaviours on every clock. A stopped counter holds its value, and code 1 advances by exactly one per clock. A wrap from all ones sets the flag, and a bus write to the count beats a pending advance. An acknowledge drops the request, a zero written to the flag leaves it set, and the request stays low without its mask and enable.

Some behaviours only the bench's scenarios can show. These are the exact period of each divided rate and the prescaler restart after a changed code. They also include the two-to-three-clock latency from an external pin edge and the flag surviving a clear that coincides with an overflow. The bench shows these by comparing against a reference model through long runs at each code.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

   localparam int CS_W   = 3;
   localparam int ADDR_W = 2;

   typedef enum logic [CS_W-1:0] {
      CS_STOP   = 3'd0,
      CS_DIV1   = 3'd1,
      CS_DIV8   = 3'd2,
      CS_DIV64  = 3'd3,
      CS_DIV256 = 3'd4,
      CS_DIV1K  = 3'd5,
      CS_EXT_FALL = 3'd6,
      CS_EXT_RISE = 3'd7
   } cs_code_e;

   localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd1;
   localparam logic [ADDR_W-1:0] A_FLAG  = 2'd2;
   localparam logic [ADDR_W-1:0] A_MASK  = 2'd3;

   // log2 of the division ratio for the divided-clock codes
   function automatic int div_log2(input int code);
      case (code)
         1: return 0;
         2: return 3;
         3: return 6;
         4: return 8;
         5: return 10;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/ovf_timer_prescale.sv
module ovf_timer_prescale
   import ovf_timer_pkg::*;
#(
   parameter int PRE_W  = 10,
   parameter int SYNC_N = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CS_W-1:0] cs,
   input  logic            restart,
   input  logic            ext_pin,
   output logic            tick
);

   localparam int NDIV = 5;

   if (PRE_W < div_log2(NDIV)) begin : g_bad_pre
      $error("PRE_W too narrow for the largest division");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end

   logic [PRE_W-1:0] pre_q;
   logic [SYNC_N:0]  sync_q;
   logic [NDIV:1]    div_hit;
   logic             ext_rise, ext_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end

   // synchronizer stages plus one history stage for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_N-1:0], ext_pin};
   end

   assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
   assign ext_fall = ~sync_q[SYNC_N-1] & sync_q[SYNC_N];

   for (genvar k = 1; k <= NDIV; k++) begin : g_div
      localparam logic [PRE_W-1:0] MSK = PRE_W'((1 << div_log2(k)) - 1);
      assign div_hit[k] = ((pre_q & MSK) == MSK);
   end

   always_comb begin
      case (cs)
         CS_DIV1:     tick = div_hit[1];
         CS_DIV8:     tick = div_hit[2];
         CS_DIV64:    tick = div_hit[3];
         CS_DIV256:   tick = div_hit[4];
         CS_DIV1K:    tick = div_hit[5];
         CS_EXT_FALL: tick = ext_fall;
         CS_EXT_RISE: tick = ext_rise;
         default:     tick = 1'b0;
      endcase
   end

endmodule

// File: rtl/ovf_timer_core.sv
module ovf_timer_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         cnt_we,
   input  logic [W-1:0] cnt_wdata,
   input  logic         flag_clr,
   input  logic         ack,
   output logic [W-1:0] cnt,
   output logic         flag,
   output logic         ovf
);

   logic adv;

   assign adv = tick & ~cnt_we;
   assign ovf = adv & (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (cnt_we) cnt <= cnt_wdata;
      else if (adv)    cnt <= cnt + 1'b1;
   end

   // a new overflow outranks any clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & ~flag_clr & ~ack) | ovf;
   end

endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
   import ovf_timer_pkg::*;
#(
   parameter int W     = 16,
   parameter int PRE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   input  logic              ext_clk,
   input  logic              gie,
   input  logic              irq_ack,
   output logic              irq
);

   if (W != 8 && W != 16) begin : g_bad_w
      $error("W must be 8 or 16");
   end

   logic [CS_W-1:0] cs_q;
   logic            mask_q;
   logic [W-1:0]    cnt_q;
   logic            flag_q;
   logic            tick, ovf;
   logic            cnt_we, cs_we, flag_we, mask_we, cs_restart;

   assign cnt_we     = bus_we && bus_addr == A_COUNT;
   assign cs_we      = bus_we && bus_addr == A_CTRL;
   assign flag_we    = bus_we && bus_addr == A_FLAG;
   assign mask_we    = bus_we && bus_addr == A_MASK;
   assign cs_restart = cs_we && bus_wdata[CS_W-1:0] != cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= '0;
         mask_q <= 1'b0;
      end else begin
         if (cs_we)   cs_q   <= bus_wdata[CS_W-1:0];
         if (mask_we) mask_q <= bus_wdata[0];
      end
   end

   ovf_timer_prescale #(.PRE_W(PRE_W), .SYNC_N(2)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (cs_q),
      .restart (cs_restart),
      .ext_pin (ext_clk),
      .tick    (tick)
   );

   ovf_timer_core #(.W(W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt_we    (cnt_we),
      .cnt_wdata (bus_wdata),
      .flag_clr  (flag_we & bus_wdata[0]),
      .ack       (irq_ack),
      .cnt       (cnt_q),
      .flag      (flag_q),
      .ovf       (ovf)
   );

   assign irq = flag_q & mask_q & gie;

   always_comb begin
      case (bus_addr)
         A_COUNT: bus_rdata = cnt_q;
         A_CTRL:  bus_rdata = {{(W-CS_W){1'b0}}, cs_q};
         A_FLAG:  bus_rdata = {{(W-1){1'b0}}, flag_q};
         default: bus_rdata = {{(W-1){1'b0}}, mask_q};
      endcase
   end

endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   cs_q,
   input logic [W-1:0] cnt_q,
   input logic         flag_q,
   input logic         mask_q,
   input logic         tick,
   input logic         cnt_we,
   input logic         flag_we,
   input logic [W-1:0] bus_wdata,
   input logic         gie,
   input logic         irq_ack,
   input logic         irq
);

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q == 3'd0 && !cnt_we) |=> $stable(cnt_q)); // R2

   AST_DIV1_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q == 3'd1 && !cnt_we) |=> cnt_q == W'($past(cnt_q) + 1'b1)); // R3

   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_we && &cnt_q) |=> (flag_q && cnt_q == '0)); // R5

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie || !mask_q) |-> !irq); // R6

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !(tick && !cnt_we && &cnt_q)) |=> !irq); // R7

   AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && flag_we && !bus_wdata[0] && !irq_ack) |=> flag_q); // R8

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> cnt_q == $past(bus_wdata)); // R9

endmodule

bind ovf_timer ovf_timer_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_q      (cs_q),
   .cnt_q     (cnt_q),
   .flag_q    (flag_q),
   .mask_q    (mask_q),
   .tick      (tick),
   .cnt_we    (cnt_we),
   .flag_we   (flag_we),
   .bus_wdata (bus_wdata),
   .gie       (gie),
   .irq_ack   (irq_ack),
   .irq       (irq)
);

// File: tb/ovf_timer_test.sv
module ovf_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         ext_clk = 1'b0;
   logic         gie = 1'b0;
   logic         irq_ack = 1'b0;
   logic         irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string req = "R1";

   // reference model state
   int m_cnt = 0, m_cs = 0, m_flag = 0, m_mask = 0, m_phase = 0;
   int ext_hist[$] = '{0, 0, 0};

   ovf_timer #(.W(W), .PRE_W(10)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ext_clk   (ext_clk),
      .gie       (gie),
      .irq_ack   (irq_ack),
      .irq       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int ratio(int c);
      case (c)
         1: return 1;
         2: return 8;
         3: return 64;
         4: return 256;
         5: return 1024;
         default: return 0;
      endcase
   endfunction

   task automatic model_step();
      int  tk;
      int  w;
      int  rise, fall;
      bit  cw;
      w    = int'(bus_wdata);
      rise = (ext_hist[1] == 1 && ext_hist[2] == 0);
      fall = (ext_hist[1] == 0 && ext_hist[2] == 1);
      if (m_cs >= 1 && m_cs <= 5) tk = ((m_phase % ratio(m_cs)) == ratio(m_cs) - 1);
      else if (m_cs == 6)        tk = fall;
      else if (m_cs == 7)        tk = rise;
      else                       tk = 0;
      cw = bus_we && bus_addr == 2'd0;
      if (cw) m_cnt = w;
      else if (tk != 0) begin
         if (m_cnt == MAXV) begin
            m_cnt  = 0;
            m_flag = 1;
         end else begin
            m_cnt = m_cnt + 1;
            if (bus_we && bus_addr == 2'd2 && w[0]) m_flag = 0;
            if (irq_ack) m_flag = 0;
         end
      end
      if (!(tk != 0 && !cw && m_cnt == 0 && m_flag == 1 && !cw)) begin
         // no overflow this cycle: apply clears
         if (bus_we && bus_addr == 2'd2 && w[0]) m_flag = 0;
         if (irq_ack) m_flag = 0;
      end
      if (bus_we && bus_addr == 2'd3) m_mask = w & 1;
      if (bus_we && bus_addr == 2'd1 && (w & 7) != m_cs) begin
         m_cs    = w & 7;
         m_phase = 0;
      end else m_phase = (m_phase + 1) % 1024;
      ext_hist.push_front(int'(ext_clk));
      void'(ext_hist.pop_back());
   endtask

   task automatic compare();
      int exp_rd, exp_irq;
      case (bus_addr)
         2'd0: exp_rd = m_cnt;
         2'd1: exp_rd = m_cs;
         2'd2: exp_rd = m_flag;
         default: exp_rd = m_mask;
      endcase
      exp_irq = m_flag & m_mask & int'(gie);
      checks++;
      if (int'(bus_rdata) != exp_rd || int'(irq) != exp_irq) begin
         fails++;
         $display("FAIL %s addr=%0d rdata=%0d irq=%0d expected rdata=%0d irq=%0d",
                  req, bus_addr, bus_rdata, irq, exp_rd, exp_irq);
      end
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic cyc();
      bit ov_pending;
      @(posedge clk);
      ov_pending = 1'b0;
      if (rst_n) model_step();
      @(negedge clk);
      compare();
      bus_we  = 1'b0;
      irq_ack = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      bus_we    = 1'b1;
      bus_addr  = 2'(a);
      bus_wdata = W'(d);
      cyc();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         bus_addr = 2'(i % 4);
         cyc();
      end
   endtask

   task automatic direct(input int act, input int exp, input string r);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s direct check actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired (R1 run did not finish)");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 / R10: reset values on every address
      req = "R1";
      for (int a = 0; a < 4; a++) begin
         bus_addr = 2'(a);
         #1;
         direct(int'(bus_rdata), 0, "R1");
      end
      idle(4);

      req = "R2";
      idle(12);

      // R3: each divided rate, including a same-code rewrite
      req = "R3";
      wr(1, 1);
      idle(20);
      wr(1, 2);
      idle(30);
      wr(1, 2);
      idle(30);
      wr(1, 3);
      idle(200);
      wr(1, 4);
      idle(600);
      wr(1, 5);
      idle(2200);

      // R10: upper control bits are dropped
      req = "R10";
      wr(1, 8'hF9);
      bus_addr = 2'd1;
      #1;
      direct(int'(bus_rdata), 1, "R10");
      idle(8);

      // R5 / R6 / R7: wrap, interrupt gating and acknowledge
      req = "R5";
      wr(0, MAXV - 3);
      idle(6);
      req = "R6";
      wr(3, 1);
      idle(3);
      gie = 1'b1;
      idle(3);
      bus_addr = 2'd2;
      #1;
      direct(int'(irq), 1, "R6");
      req = "R7";
      irq_ack = 1'b1;
      cyc();
      direct(int'(irq), 0, "R7");
      idle(4);

      // R8: writing 0 keeps the flag, writing 1 clears it
      req = "R8";
      wr(0, MAXV - 1);
      idle(4);
      wr(2, 0);
      idle(2);
      wr(2, 1);
      idle(3);

      // R11: clear coinciding with an overflow
      req = "R11";
      wr(0, MAXV);
      wr(2, 1);
      idle(3);
      wr(0, MAXV);
      irq_ack = 1'b1;
      bus_addr = 2'd2;
      cyc();
      idle(3);

      // R9: count writes beat ticks
      req = "R9";
      for (int i = 0; i < 10; i++) wr(0, 16 * i + 5);
      idle(4);

      // R4: external edges, rising then falling
      req = "R4";
      wr(1, 7);
      for (int i = 0; i < 40; i++) begin
         if (i % 3 == 0) ext_clk = ~ext_clk;
         bus_addr = 2'(i % 4);
         cyc();
      end
      wr(1, 6);
      for (int i = 0; i < 40; i++) begin
         if (i % 5 == 0) ext_clk = ~ext_clk;
         bus_addr = 2'(i % 4);
         cyc();
      end
      wr(1, 0);
      req = "R2";
      idle(10);

      finish_run();
   end

endmodule